// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block paces the periodic refresh of a DDR SDRAM rank on behalf of a memory controller. A free-running interval counter adds one refresh to an owed-refresh credit each time a refresh period (7.8 us, expressed in controller clock cycles) elapses. Whenever the bank scheduler reports that every bank is precharged, one owed refresh is paid off by putting the AUTO REFRESH encoding on the command lines. When too many refreshes have been deferred, an urgent flag tells the bank scheduler to close its rows. After each refresh it blocks further commands for the refresh cycle time.

The same block moves the rank into and out of self-refresh. A host request, once the banks are idle and no hold-off is running, issues the refresh encoding with clock enable driven low. While in self-refresh the device refreshes itself: the owed credit is cleared and the interval counter stops. When the request is withdrawn, clock enable returns high. Two separate hold-offs then apply: a short one for non-read commands and a longer one, counted in clock cycles, for reads.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset the command output is NOP (3'b111, bit order {ras_n, cas_n, we_n}), clock enable is 1, the owed count is 0, and urgent, hold_nonread and hold_read are 0.
- R2: While running, the owed count goes up by one once every TICK cycles, where TICK = ceil(REFI_NS*1000 / TCK_PS); the first increment follows the TICK-th clock edge after reset or after self-refresh exit.
- R3: The owed count never exceeds MAX_OWED; an increment at MAX_OWED is dropped; ref_urgent is 1 exactly when the owed count equals MAX_OWED.
- R4: AUTO REFRESH (3'b001 with clock enable 1) appears for one cycle, in the cycle after an edge where banks_idle is 1, sr_req is 0, the owed count is nonzero and hold_nonread is 0; it lowers the owed count by one (an increment on the same edge cancels it).
- R5: After an AUTO REFRESH, hold_nonread stays 1 for RFC = ceil(RFC_NS*1000 / TCK_PS) cycles counted from the command cycle, and no further refresh issues in that window.
- R6: Self-refresh entry happens on an edge where sr_req and banks_idle are 1 and hold_nonread is 0: in the next cycle the command is 3'b001 with clock enable 0, and the owed count is 0; both hold outputs are 1 while clock enable is 0.
- R7: While in self-refresh the owed count stays 0 and the command stays NOP; one cycle after sr_req drops, clock enable is 1, hold_nonread stays 1 for XSNR = ceil(XSNR_NS*1000 / TCK_PS) cycles and hold_read for XSRD_CYC cycles.
- R8: In every cycle that is neither a refresh nor a self-refresh entry the command output is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Host request to be in self-refresh |
| banks_idle | input | 1 | All banks precharged, from the bank scheduler |
| ref_urgent | output | 1 | Owed-refresh credit is full |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of refreshes currently owed |
| cmd_o | output | 3 | Command encoding {ras_n, cas_n, we_n} |
| cke_o | output | 1 | Clock enable toward the device |
| hold_nonread | output | 1 | Non-read commands must not issue |
| hold_read | output | 1 | READ commands must not issue |

## Verification
The bench builds the block with a 5 ns cycle, a 100 ns refresh interval, a 20 ns refresh cycle time, a 25 ns non-read exit delay and a 12-cycle read exit delay, so TICK is 20, RFC is 4 and XSNR is 5 while MAX_OWED stays at 8. With these values the credit fills to saturation in 160 cycles, drains under back-to-back refreshes with ticks landing on the same edge as issues, and self-refresh entry, the blocked entry during a hold-off and both exit windows all fit in a few hundred cycles, each compared cycle by cycle against an arithmetic model of the requirements.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

  typedef enum logic [2:0] {
    CMD_AREF = 3'b001,
    CMD_NOP  = 3'b111
  } rfs_cmd_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SELF = 1'b1
  } rfs_state_e;

  // whole cycles needed to cover a duration
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // saturating credit update
  function automatic int next_owed(input int cur, input logic inc,
                                   input logic dec, input int maxv);
    int n;
    n = cur + (inc ? 1 : 0) - (dec ? 1 : 0);
    if (n > maxv) n = maxv;
    if (n < 0) n = 0;
    return n;
  endfunction

endpackage

// File: rtl/rfs_tick.sv
`timescale 1ns/1ps
module rfs_tick #(
  parameter int LIMIT = 1040,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == W'(LIMIT - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (at_end)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfs_credit.sv
`timescale 1ns/1ps
module rfs_credit #(
  parameter int MAXV = 8,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         clr,
  output logic [W-1:0] owed,
  output logic         full
);
  logic [W-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) owed_q <= '0;
    else owed_q <= W'(rfs_pkg::next_owed(int'(owed_q), inc, dec, MAXV));
  end

  assign owed = owed_q;
  assign full = (owed_q == W'(MAXV));
endmodule

// File: rtl/rfs_holdoff.sv
`timescale 1ns/1ps
module rfs_holdoff #(
  parameter int LOAD = 10,
  localparam int W = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= W'(LOAD);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
  parameter int TCK_PS    = 7500,
  parameter int REFI_NS   = 7800,
  parameter int RFC_NS    = 75,
  parameter int XSNR_NS   = 75,
  parameter int XSRD_CYC  = 200,
  parameter int MAX_OWED  = 8,
  localparam int OW       = $clog2(MAX_OWED + 1),
  localparam int TICK_CYC = rfs_pkg::ceil_div(REFI_NS * 1000, TCK_PS),
  localparam int RFC_CYC  = rfs_pkg::ceil_div(RFC_NS * 1000, TCK_PS),
  localparam int XSNR_CYC = rfs_pkg::ceil_div(XSNR_NS * 1000, TCK_PS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_req,
  input  logic          banks_idle,
  output logic          ref_urgent,
  output logic [OW-1:0] owed_cnt,
  output logic [2:0]    cmd_o,
  output logic          cke_o,
  output logic          hold_nonread,
  output logic          hold_read
);
  import rfs_pkg::*;

  rfs_state_e state_q;
  rfs_cmd_e   cmd_q;
  logic       cke_q;

  // named internal events
  logic tick_ev, enter_ev, fire_ev, leave_ev, run_ev;
  logic rfc_busy, xsnr_busy, xsrd_busy, blk_nr;

  assign blk_nr   = rfc_busy || xsnr_busy;
  assign enter_ev = (state_q == ST_RUN) && sr_req && banks_idle && !blk_nr;
  assign fire_ev  = (state_q == ST_RUN) && !sr_req && banks_idle && !blk_nr
                    && (owed_cnt != '0);
  assign leave_ev = (state_q == ST_SELF) && !sr_req;
  assign run_ev   = (state_q == ST_RUN) && !enter_ev;

  rfs_tick #(.LIMIT(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_ev), .tick(tick_ev)
  );

  rfs_credit #(.MAXV(MAX_OWED)) u_credit (
    .clk(clk), .rst_n(rst_n), .inc(tick_ev), .dec(fire_ev), .clr(enter_ev),
    .owed(owed_cnt), .full(ref_urgent)
  );

  rfs_holdoff #(.LOAD(RFC_CYC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .start(fire_ev || enter_ev), .busy(rfc_busy)
  );

  rfs_holdoff #(.LOAD(XSNR_CYC)) u_xsnr (
    .clk(clk), .rst_n(rst_n), .start(leave_ev), .busy(xsnr_busy)
  );

  rfs_holdoff #(.LOAD(XSRD_CYC)) u_xsrd (
    .clk(clk), .rst_n(rst_n), .start(leave_ev), .busy(xsrd_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cmd_q   <= CMD_NOP;
      cke_q   <= 1'b1;
    end else begin
      cmd_q <= (enter_ev || fire_ev) ? CMD_AREF : CMD_NOP;
      if (enter_ev) begin
        state_q <= ST_SELF;
        cke_q   <= 1'b0;
      end else if (leave_ev) begin
        state_q <= ST_RUN;
        cke_q   <= 1'b1;
      end
    end
  end

  assign cmd_o        = cmd_q;
  assign cke_o        = cke_q;
  assign hold_nonread = (state_q == ST_SELF) || blk_nr;
  assign hold_read    = hold_nonread || xsrd_busy;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
`timescale 1ns/1ps
module dram_refresh_sched_chk #(
  parameter int OW = 4,
  parameter int MAX_OWED = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          banks_idle,
  input logic          sr_req,
  input logic          ref_urgent,
  input logic [OW-1:0] owed_cnt,
  input logic [2:0]    cmd_o,
  input logic          cke_o,
  input logic          hold_nonread,
  input logic          hold_read
);
  // R3
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed_cnt) <= MAX_OWED);
  // R3
  urgent_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent == (int'(owed_cnt) == MAX_OWED));
  // R4
  aref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'b001 && cke_o) |-> $past(banks_idle) && !$past(sr_req));
  // R5
  aref_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'b001) |-> hold_nonread);
  // R5
  aref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'b001) |=> (cmd_o == 3'b111));
  // R6
  entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> (cmd_o == 3'b001));
  // R6
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (owed_cnt == '0) && hold_nonread && hold_read);
  // R7
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> hold_nonread && hold_read);
  // R7
  read_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_nonread |-> hold_read);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .OW(OW), .MAX_OWED(MAX_OWED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sr_req(sr_req),
  .ref_urgent(ref_urgent), .owed_cnt(owed_cnt), .cmd_o(cmd_o), .cke_o(cke_o),
  .hold_nonread(hold_nonread), .hold_read(hold_read)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int TCK = 5000, REFI = 100, RFCN = 20, XSNRN = 25, XSRD = 12;
  localparam int MAXO = 8;
  localparam int T    = (REFI * 1000 + TCK - 1) / TCK;   // 20
  localparam int RFC  = (RFCN * 1000 + TCK - 1) / TCK;   // 4
  localparam int XSNR = (XSNRN * 1000 + TCK - 1) / TCK;  // 5
  localparam int OW   = $clog2(MAXO + 1);

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0, banks_idle = 1'b0;
  logic ref_urgent, cke_o, hold_nonread, hold_read;
  logic [OW-1:0] owed_cnt;
  logic [2:0] cmd_o;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .TCK_PS(TCK), .REFI_NS(REFI), .RFC_NS(RFCN), .XSNR_NS(XSNRN),
    .XSRD_CYC(XSRD), .MAX_OWED(MAXO)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .banks_idle(banks_idle),
    .ref_urgent(ref_urgent), .owed_cnt(owed_cnt), .cmd_o(cmd_o),
    .cke_o(cke_o), .hold_nonread(hold_nonread), .hold_read(hold_read)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int aref_seen = 0, entries = 0;

  // arithmetic model of the requirements
  bit m_self = 0, m_cke = 1;
  int m_tc = 0, m_owed = 0, m_rfc = 0, m_xn = 0, m_xr = 0;
  logic [2:0] m_cmd = 3'b111;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dec0(input int v);
    return (v > 0) ? v - 1 : 0;
  endfunction

  task automatic step();
    bit blk, enter, fire, tk;
    @(posedge clk);
    blk = (m_rfc != 0) || (m_xn != 0);
    if (m_self) begin
      m_cmd = 3'b111;
      m_rfc = dec0(m_rfc);
      if (!sr_req) begin
        m_self = 0; m_cke = 1; m_xn = XSNR; m_xr = XSRD;
      end else begin
        m_xn = dec0(m_xn); m_xr = dec0(m_xr);
      end
    end else begin
      enter = sr_req && banks_idle && !blk;
      fire  = !sr_req && banks_idle && !blk && (m_owed > 0);
      tk    = !enter && (m_tc == T - 1);
      m_tc  = (enter || tk) ? 0 : m_tc + 1;
      if (enter) begin
        m_self = 1; m_cke = 0; m_owed = 0; entries++;
      end else begin
        m_owed = m_owed + (tk ? 1 : 0) - (fire ? 1 : 0);
        if (m_owed > MAXO) m_owed = MAXO;
      end
      m_cmd = (enter || fire) ? 3'b001 : 3'b111;
      m_rfc = (enter || fire) ? RFC : dec0(m_rfc);
      m_xn = dec0(m_xn); m_xr = dec0(m_xr);
    end
    @(negedge clk);
    begin
      bit e_hn, e_hr;
      e_hn = m_self || (m_rfc != 0) || (m_xn != 0);
      e_hr = e_hn || (m_xr != 0);
      if (cmd_o == 3'b001 && cke_o) aref_seen++;
      chk(int'(owed_cnt) == m_owed, "R2 owed count", int'(owed_cnt), m_owed);
      chk(ref_urgent == (m_owed == MAXO), "R3 urgent", int'(ref_urgent), int'(m_owed == MAXO));
      chk(cmd_o == m_cmd, "R4/R8 command", int'(cmd_o), int'(m_cmd));
      chk(cke_o == m_cke, "R6/R7 clock enable", int'(cke_o), int'(m_cke));
      chk(hold_nonread == e_hn, "R5/R7 hold_nonread", int'(hold_nonread), int'(e_hn));
      chk(hold_read == e_hr, "R7 hold_read", int'(hold_read), int'(e_hr));
    end
  endtask

  task automatic run(input int n, input bit idle, input bit sr);
    banks_idle = idle; sr_req = sr;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cmd_o == 3'b111, "R1 cmd", int'(cmd_o), 7);
    chk(cke_o == 1'b1, "R1 cke", int'(cke_o), 1);
    chk(owed_cnt == '0, "R1 owed", int'(owed_cnt), 0);
    chk(!ref_urgent && !hold_nonread && !hold_read, "R1 flags",
        int'({ref_urgent, hold_nonread, hold_read}), 0);
    rst_n = 1'b1;

    // R2 R3: banks busy, credit fills and saturates
    run(T * MAXO + 3 * T, 1'b0, 1'b0);
    chk(int'(owed_cnt) == MAXO, "R3 saturated", int'(owed_cnt), MAXO);
    // R4 R5: drain under back-to-back refreshes
    aref_seen = 0;
    run(60, 1'b1, 1'b0);
    chk(aref_seen >= MAXO, "R4 refreshes issued", aref_seen, MAXO);
    // mixed idle pattern
    for (int c = 0; c < 150; c++) run(1, (c % 3) != 0, 1'b0);
    // R6: entry blocked while banks busy, then taken
    run(5, 1'b0, 1'b1);
    chk(cke_o == 1'b1, "R6 entry waits for idle", int'(cke_o), 1);
    run(40, 1'b1, 1'b1);
    chk(cke_o == 1'b0 && owed_cnt == '0, "R6 in self-refresh",
        int'({cke_o, owed_cnt}), 0);
    // R7: exit and both windows
    run(30, 1'b1, 1'b0);
    // re-entry requested straight after a refresh is held off
    run(30, 1'b0, 1'b0);
    run(1, 1'b1, 1'b0);
    run(8, 1'b1, 1'b1);
    run(5, 1'b1, 1'b1);
    run(3, 1'b0, 1'b0);
    run(T * 3, 1'b0, 1'b0);
    chk(entries == 2, "R6 entry count", entries, 2);
    run(40, 1'b1, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule